// File: doc/BRIEF.md
# Bit-Serial Carry-Save Resolver with Serial-Parallel Multiplier

This block sits in the inner loop of a modular exponentiation datapath. A previous modular product reaches it in redundant form, as two vectors (a sum vector and a carry vector). Both vectors arrive one bit position per clock, least significant position first. A one-flip-flop ripple adder folds each pair of bits into a single binary bit in the same cycle. That bit goes at once into a serial-parallel multiplier as its serial operand. The parallel operand is captured from a port when the run starts. Because conversion and multiplication share the same cycle, neither stage waits for the other.

Let N be the modulus width. The operands are W = N+1 bits wide. The multiplier sends out the lowest N+2 bits of the 2N+2-bit product, one bit per clock with a valid strobe, so a reducer downstream can start work on the first bit. After those bits it stops shifting. The remaining N upper bits stay frozen on a parallel port for a later addition. A run takes N+2 cycles after the start edge. A one-cycle done pulse ends the run. Squaring uses the same path: the value that arrives serially is also presented as the parallel operand.

Top module: `spm_cpa_mult`

## Requirements
- R1: After synchronous active-low reset, lo_vld, done and busy are 0 and hi_prod is 0.
- R2: A start sampled high while busy is 0 captures op_b, clears the adder carry and the accumulator, and makes busy 1 on the next cycle. op_b changes after that edge do not affect the run.
- R3: The serial operand A is (S + C) mod 2^W. S and C bit k are presented on cs_sum and cs_carry in the k-th cycle after the start edge, for k = 0..W-1. Carry out of position W-1 is discarded.
- R4: Exactly N+2 lo_vld pulses follow a start, on consecutive cycles. Low product bit k is on lo_bit in the (k+1)-th cycle after the start edge, least significant bit first.
- R5: When done is high, hi_prod equals product bits 2N+1 down to N+2. It holds that value while no new run is started.
- R6: done is a single-cycle pulse that coincides with the last lo_vld pulse. busy is 0 in that same cycle.
- R7: A start sampled while busy is 1 is ignored, and the running product is unchanged.
- R8: A carry left in the adder at the end of one run does not leak into the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| op_b | input | N+1 | Parallel operand, captured at start |
| cs_sum | input | 1 | Serial sum-vector bit, LSB first |
| cs_carry | input | 1 | Serial carry-vector bit, same weight as cs_sum |
| lo_bit | output | 1 | Serial low product bit |
| lo_vld | output | 1 | lo_bit is valid |
| hi_prod | output | N | Upper product bits, held after done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with N = 16, so the operands are 17 bits and the full product is 34 bits. Every product therefore fits a 64-bit bench integer and can be compared bit for bit against a plain multiply. At this width the all-ones operands, carry vectors whose sum overflows 2^17, and a zero parallel operand can all be tried directly. Each run is short enough that many random operand pairs fit alongside the directed cases.

// File: rtl/spm_pkg.sv
// Shared types for the serial carry-save resolver and multiplier.
package spm_pkg;
    // Run phase of the sequencer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;
endpackage

// File: rtl/spm_serial_cpa.sv
// Bit-serial carry-propagate adder: folds one carry-save bit pair per clock
// into one binary bit. Assumes both input bits carry the same weight.
// The output is combinational so it can feed the multiplier in the same cycle.
module spm_serial_cpa (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic sum_bit,
    input  logic car_bit,
    output logic bin_bit
);
    logic cy_q;

    // Binary bit of the current weight.
    always_comb bin_bit = sum_bit ^ car_bit ^ cy_q;

    // Single carry flop, cleared at the start of each run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cy_q <= 1'b0;
        else if (clr)
            cy_q <= 1'b0;
        else if (adv)
            cy_q <= (sum_bit & car_bit) | (sum_bit & cy_q) | (car_bit & cy_q);
    end
endmodule

// File: rtl/spm_serpar_mult.sv
// Serial-parallel multiplier. It adds a_bit*B to the accumulator each step,
// sends out the LSB of the sum and shifts the rest right.
// Assumes the caller zeros a_bit on the flush step after the W operand bits.
module spm_serpar_mult #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] b_in,
    input  logic         step,
    input  logic         a_bit,
    output logic         lo_bit,
    output logic         lo_vld,
    output logic [W-1:0] acc
);
    logic [W-1:0] b_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] pp;
    logic [W-1:0] srow;
    logic [W:0]   ch;
    logic [W:0]   row;

    assign ch[0] = 1'b0;

    // One full-adder cell per operand bit forms accumulator + partial product.
    for (genvar j = 0; j < W; j++) begin : g_cell
        assign pp[j]   = a_bit & b_q[j];
        assign srow[j] = acc_q[j] ^ pp[j] ^ ch[j];
        assign ch[j+1] = (acc_q[j] & pp[j]) | (acc_q[j] & ch[j]) | (pp[j] & ch[j]);
    end

    assign row = {ch[W], srow};
    assign acc = acc_q;

    // Operand capture, accumulate-and-shift, and serial output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q    <= '0;
            acc_q  <= '0;
            lo_bit <= 1'b0;
            lo_vld <= 1'b0;
        end else if (load) begin
            b_q    <= b_in;
            acc_q  <= '0;
            lo_bit <= 1'b0;
            lo_vld <= 1'b0;
        end else if (step) begin
            acc_q  <= row[W:1];
            lo_bit <= row[0];
            lo_vld <= 1'b1;
        end else begin
            lo_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/spm_seq.sv
// Run sequencer. It accepts start only when idle, then steps W operand
// cycles plus one flush cycle, and pulses done on the last one.
module spm_seq #(
    parameter int W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic feed,
    output logic busy,
    output logic done
);
    import spm_pkg::*;

    localparam int CW = $clog2(W + 1);

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Decode the control strobes from the phase and the counter.
    always_comb begin
        busy = (ph_q == PH_RUN);
        load = start && (ph_q == PH_IDLE);
        step = (ph_q == PH_RUN);
        feed = step && (cnt_q < CW'(W));
    end

    assign done = done_q;

    // Phase, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                ph_q  <= PH_RUN;
                cnt_q <= '0;
            end else if (step) begin
                if (cnt_q == CW'(W)) begin
                    ph_q   <= PH_IDLE;
                    done_q <= 1'b1;
                end
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spm_cpa_mult.sv
// Top: a serial carry-save resolver feeding a serial-parallel multiplier.
// Sends out N+2 low product bits serially, then holds N high bits.
// Assumes cs_sum/cs_carry present bit k in the k-th cycle after start.
module spm_cpa_mult #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N:0]   op_b,
    input  logic         cs_sum,
    input  logic         cs_carry,
    output logic         lo_bit,
    output logic         lo_vld,
    output logic [N-1:0] hi_prod,
    output logic         busy,
    output logic         done
);
    localparam int W = N + 1;

    logic         load;
    logic         step;
    logic         feed;
    logic         bin_bit;
    logic         a_bit;
    logic [W-1:0] acc;

    spm_seq #(.W(W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .feed(feed), .busy(busy), .done(done)
    );

    spm_serial_cpa cpa_i (
        .clk(clk), .rst_n(rst_n), .clr(load), .adv(feed),
        .sum_bit(cs_sum), .car_bit(cs_carry), .bin_bit(bin_bit)
    );

    // Zero the serial operand on the flush step.
    always_comb a_bit = feed & bin_bit;

    spm_serpar_mult #(.W(W)) mul_i (
        .clk(clk), .rst_n(rst_n), .load(load), .b_in(op_b),
        .step(step), .a_bit(a_bit),
        .lo_bit(lo_bit), .lo_vld(lo_vld), .acc(acc)
    );

    assign hi_prod = acc[N-1:0];
endmodule

// File: rtl/spm_cpa_mult_chk.sv
// Protocol checker for spm_cpa_mult, attached with bind.
module spm_cpa_mult_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         lo_vld,
    input logic [N-1:0] hi_prod,
    input logic         busy,
    input logic         done
);
    logic [15:0] vld_cnt;

    // Count the valid low bits since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_cnt <= '0;
        else if (start && !busy)
            vld_cnt <= '0;
        else if (lo_vld)
            vld_cnt <= vld_cnt + 1'b1;
    end

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r4_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(vld_cnt) + 32'd1 == N + 2));

    a_r5_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(hi_prod));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lo_vld && !busy));

    a_r4_vld_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        lo_vld |-> $past(busy));
endmodule

bind spm_cpa_mult spm_cpa_mult_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lo_vld(lo_vld),
    .hi_prod(hi_prod), .busy(busy), .done(done)
);

// File: tb/spm_cpa_mult_tb_top.sv
module spm_cpa_mult_tb_top;
    localparam int N = 16;
    localparam int W = N + 1;
    localparam int NV = 9;

    // Each entry: {S, C, B}, 17 bits each.
    localparam logic [3*W-1:0] VEC [NV] = '{
        {17'h00000, 17'h00000, 17'h00000},
        {17'h00001, 17'h00000, 17'h00001},
        {17'h1FFFF, 17'h00000, 17'h1FFFF},
        {17'h0AAAA, 17'h05555, 17'h1FFFF},
        {17'h1FFFF, 17'h1FFFF, 17'h00003},
        {17'h12345, 17'h00F0F, 17'h0ABCD},
        {17'h10000, 17'h10000, 17'h1FFFF},
        {17'h0F0F0, 17'h0F0F0, 17'h10001},
        {17'h00001, 17'h00001, 17'h00000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N:0]   op_b = '0;
    logic         cs_sum = 1'b0;
    logic         cs_carry = 1'b0;
    logic         lo_bit;
    logic         lo_vld;
    logic [N-1:0] hi_prod;
    logic         busy;
    logic         done;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    spm_cpa_mult #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_b(op_b),
        .cs_sum(cs_sum), .cs_carry(cs_carry), .lo_bit(lo_bit),
        .lo_vld(lo_vld), .hi_prod(hi_prod), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One run: S and C stream serially, B goes in parallel. poke drives a
    // start while busy to test that it is ignored.
    task automatic run_op(input logic [W-1:0] s, input logic [W-1:0] c,
                          input logic [W-1:0] b, input bit poke);
        logic [W-1:0]  a;
        logic [63:0]   p;
        logic [W:0]    got;
        logic [N-1:0]  hi_seen;
        a = W'(({1'b0, s} + {1'b0, c}) & {1'b0, {W{1'b1}}});
        p = 64'(a) * 64'(b);
        got = '0;
        @(negedge clk);
        op_b = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_b = ~b;
        check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        for (int i = 0; i <= W; i++) begin
            cs_sum   = (i < W) ? s[i] : 1'b0;
            cs_carry = (i < W) ? c[i] : 1'b0;
            start    = poke && (i == 3);
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            got[i] = lo_bit;
            check(lo_vld == 1'b1, "R4 lo_vld each cycle", 64'(lo_vld), 64'd1);
            check(done == (i == W), "R6 done on last bit", 64'(done), 64'(i == W));
            check(busy == (i < W), "R6 busy", 64'(busy), 64'(i < W));
        end
        check(got == p[W:0], "R3 R4 low product bits", 64'(got), 64'(p[W:0]));
        check(hi_prod == p[2*W-1:W+1], "R5 high product", 64'(hi_prod), 64'(p[2*W-1:W+1]));
        hi_seen = hi_prod;
        repeat (3) @(negedge clk);
        check(lo_vld == 1'b0 && done == 1'b0, "R6 quiet after done",
              64'({lo_vld, done}), 64'd0);
        check(hi_prod == hi_seen, "R5 high part held", 64'(hi_prod), 64'(hi_seen));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({lo_vld, done, busy} == 3'b000, "R1 strobes idle",
              64'({lo_vld, done, busy}), 64'd0);
        check(hi_prod == '0, "R1 hi_prod zero", 64'(hi_prod), 64'd0);

        // Vector table: R3 R4 R5 R6
        for (int v = 0; v < NV; v++)
            run_op(VEC[v][3*W-1:2*W], VEC[v][2*W-1:W], VEC[v][W-1:0], 1'b0);

        // R8: run that leaves a carry, then a small operand
        run_op(17'h1FFFF, 17'h1FFFF, 17'h00005, 1'b0);
        run_op(17'h00001, 17'h00000, 17'h00001, 1'b0);

        // R7: start while busy is ignored
        run_op(17'h0BEEF, 17'h01234, 17'h1ACE5, 1'b1);
        run_op(17'h1FFFF, 17'h00000, 17'h1FFFF, 1'b1);

        // Squaring: same value serially and in parallel
        run_op(17'h0C3A5, 17'h00000, 17'h0C3A5, 1'b0);

        // Random operands
        for (int r = 0; r < 20; r++)
            run_op(W'($urandom), W'($urandom), W'($urandom), r[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule